// File: doc/BRIEF.md
# I2C Configuration Save/Restore Command Target

This block is an I2C target that listens for a short two-byte command. It tells a nonvolatile sequencer either to copy the whole configuration register bank into nonvolatile storage or to reload the bank from it. The SCL and SDA lines are sampled with the system clock through synchronizers, and START and STOP are recognised from the sampled levels. The target matches its 7-bit device address and accepts only a write. It then captures one command byte and waits for the STOP. Only when the STOP arrives does it send a one-cycle request to the sequencer.

The sequencer reports a running operation on `busy`. While `busy` is high the target stays silent and does not acknowledge. A master addressing it therefore sees NACK until the operation has finished. Save requests are also gated by an active-low write-enable input.

Multi-byte register access, clock stretching and 10-bit addressing are not handled. SDA is driven open-drain through an output enable, where 1 means pull low.

Top module: `cfg_save_restore_target`

## Requirements
- R1: The first byte after START is sent MSB first. Bits 7..1 are the address and bit 0 is R/W. The target acknowledges it only when the address equals `DEV_ADDR` and R/W is 0. A read request (R/W = 1) is answered with NACK.
- R2: If the command byte has bits [1:0] = 01 and `nv_we_n` is low at STOP, `start_save` pulses high for exactly one clock. Bits [7:2] of the command byte have no effect.
- R3: If the command byte has bits [1:0] = 10, `start_restore` pulses high for exactly one clock after the STOP. Bits [7:2] have no effect.
- R4: No request pulse appears before the STOP. Once the STOP is seen, the pulse appears within five clocks of the SDA rising edge that forms it.
- R5: While `busy` is high, the address byte gets no acknowledge and no request is issued. Once `busy` is low again, valid commands are acknowledged and executed normally.
- R6: If the address does not match, the address byte gets NACK, the following byte gets no acknowledge, and no request is issued.
- R7: A repeated START after the command byte discards the pending command, and no request is issued. The repeated START begins a new address phase.
- R8: Command bytes with bits [1:0] = 00 or 11 are acknowledged but produce no request pulse.
- R9: If `nv_we_n` is high at STOP, a save command produces no `start_save` pulse.
- R10: `sda_oe` goes high only during an acknowledge bit. It rises after the SCL falling edge that ends the eighth bit and falls after the SCL falling edge that ends the ninth bit.
- R11: After reset, `sda_oe`, `start_save` and `start_restore` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | Pull SDA low when 1 (open-drain acknowledge) |
| nv_we_n | input | 1 | Active-low write enable for nonvolatile save |
| busy | input | 1 | Sequencer is running a save or restore |
| start_save | output | 1 | One-cycle request to save the register bank |
| start_restore | output | 1 | One-cycle request to restore the register bank |

## Verification
A change on SCL or SDA reaches the edge detectors two clocks later and updates the state register on the third clock. As a result, `sda_oe` moves three clocks after the SCL falling edge that causes it, and a request pulse appears four clocks after the STOP edge. The bench keeps every SCL phase eight clocks long. It samples the acknowledge level in the middle of the ninth clock-high phase and reads the pulse counters at least eight clocks after a STOP. Pulse counters are also read just before the STOP, to show that nothing has fired early.

// File: rtl/cfg_cmd_pkg.sv
// Shared types for the save/restore command target.
// Assumes an 8-bit frame of 7 address bits plus R/W.
package cfg_cmd_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ACK_A,
        ST_CMD,
        ST_ACK_C,
        ST_WAIT_STOP,
        ST_IGNORE
    } tgt_state_e;

    // Operation selected by the two low bits of the command byte
    typedef enum logic [1:0] {
        OP_NONE    = 2'b00,
        OP_SAVE    = 2'b01,
        OP_RESTORE = 2'b10,
        OP_SPARE   = 2'b11
    } op_sel_e;

    function automatic op_sel_e op_of(input logic [BYTE_W-1:0] cmd);
        return op_sel_e'(cmd[1:0]);
    endfunction

endpackage

// File: rtl/cmd_line_sync.sv
// Synchronizes SCL and SDA into the clock domain and derives the SCL
// edges and the START/STOP conditions from the synchronized levels.
// Assumes each bus phase lasts several system clocks.
// Every detector output is valid for one clock, SYNC_STAGES clocks
// after the line change.
module cmd_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] lvl;
    logic [NLINES-1:0] lvl_d;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [SYNC_STAGES-1:0] pipe;

        // Shift the raw line through the synchronizer chain (idle high)
        always_ff @(posedge clk) begin
            if (!rst_n) pipe <= '1;
            else        pipe <= {pipe[SYNC_STAGES-2:0], raw[g]};
        end

        assign lvl[g] = pipe[SYNC_STAGES-1];
    end

    // Hold the previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= '1;
        else        lvl_d <= lvl;
    end

    assign sda_lvl   = lvl[1];
    assign scl_rise  = lvl[0] & ~lvl_d[0];
    assign scl_fall  = ~lvl[0] & lvl_d[0];
    assign start_det = lvl[0] & lvl_d[0] & lvl_d[1] & ~lvl[1];
    assign stop_det  = lvl[0] & lvl_d[0] & ~lvl_d[1] & lvl[1];

endmodule

// File: rtl/cmd_byte_fsm.sv
// Bit-level target state machine. It shifts in the address and the
// command byte, drives the acknowledge bits and raises cmd_fire for
// one clock when a STOP closes a complete command transaction.
// Assumes single-clock condition strobes from cmd_line_sync.
module cmd_byte_fsm
    import cfg_cmd_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h3C
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_lvl,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              busy,
    output logic              sda_oe,
    output logic              cmd_fire,
    output logic [BYTE_W-1:0] cmd_byte
);
    localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

    tgt_state_e        state;
    logic [3:0]        bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              addr_hit;
    logic              byte_done;

    assign addr_hit  = (shreg[BYTE_W-1:1] == DEV_ADDR) && !shreg[0];
    assign byte_done = scl_fall && (bit_cnt == LAST_BIT);

    // Advance the transaction state, shift data and drive the ACK
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            bit_cnt  <= '0;
            shreg    <= '0;
            sda_oe   <= 1'b0;
            cmd_fire <= 1'b0;
            cmd_byte <= '0;
        end else begin
            cmd_fire <= 1'b0;
            if (start_det) begin
                state   <= ST_ADDR;
                bit_cnt <= '0;
                sda_oe  <= 1'b0;
            end else if (stop_det) begin
                cmd_fire <= (state == ST_WAIT_STOP);
                state    <= ST_IDLE;
                sda_oe   <= 1'b0;
            end else begin
                unique case (state)
                    ST_ADDR, ST_CMD: begin
                        if (scl_rise && bit_cnt < LAST_BIT) begin
                            shreg   <= {shreg[BYTE_W-2:0], sda_lvl};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (byte_done) begin
                            if (busy || (state == ST_ADDR && !addr_hit)) begin
                                state <= ST_IGNORE;
                            end else begin
                                sda_oe <= 1'b1;
                                if (state == ST_CMD) begin
                                    cmd_byte <= shreg;
                                    state    <= ST_ACK_C;
                                end else begin
                                    state <= ST_ACK_A;
                                end
                            end
                        end
                    end
                    ST_ACK_A: begin
                        if (scl_fall) begin
                            sda_oe  <= 1'b0;
                            bit_cnt <= '0;
                            state   <= ST_CMD;
                        end
                    end
                    ST_ACK_C: begin
                        if (scl_fall) begin
                            sda_oe <= 1'b0;
                            state  <= ST_WAIT_STOP;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R5: an acknowledge is never started while the sequencer is busy
    p_busy_nack_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !$past(busy));

    // R10: the ACK driver only moves on an SCL fall or a bus condition
    p_ack_window_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sda_oe) || $fell(sda_oe)) |-> $past(scl_fall || start_det || stop_det));

    // R4: a command is released only by a STOP strobe
    p_fire_on_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_fire |-> $past(stop_det));

endmodule

// File: rtl/cmd_launch.sv
// Turns a completed command into a one-clock save or restore request.
// Save is qualified by the active-low write enable. Nothing is issued
// while the sequencer reports busy.
module cmd_launch
    import cfg_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_fire,
    input  logic [BYTE_W-1:0] cmd_byte,
    input  logic              nv_we_n,
    input  logic              busy,
    output logic              start_save,
    output logic              start_restore
);
    op_sel_e op;
    assign op = op_of(cmd_byte);

    // Register the request pulses from the decoded command
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_save    <= 1'b0;
            start_restore <= 1'b0;
        end else begin
            start_save    <= cmd_fire && !busy && (op == OP_SAVE) && !nv_we_n;
            start_restore <= cmd_fire && !busy && (op == OP_RESTORE);
        end
    end

    // R9: a save request needs write enable active on the previous clock
    p_save_we_r9: assert property (@(posedge clk) disable iff (!rst_n)
        start_save |-> !$past(nv_we_n));

    // R2: save request lasts a single clock
    p_save_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_save |=> !start_save);

    // R3: restore request lasts a single clock
    p_restore_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        start_restore |=> !start_restore);

endmodule

// File: rtl/cfg_save_restore_target.sv
// Top of the I2C save/restore command target. Connects the line
// synchronizer, the byte state machine and the request launcher.
// Assumes SCL phases of several system clocks and no clock stretching.
module cfg_save_restore_target #(
    parameter logic [6:0] DEV_ADDR    = 7'h3C,
    parameter int         SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe,
    input  logic nv_we_n,
    input  logic busy,
    output logic start_save,
    output logic start_restore
);
    import cfg_cmd_pkg::*;

    logic              sda_lvl;
    logic              scl_rise;
    logic              scl_fall;
    logic              start_det;
    logic              stop_det;
    logic              cmd_fire;
    logic [BYTE_W-1:0] cmd_byte;

    cmd_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_in    (scl_in),
        .sda_in    (sda_in),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    cmd_byte_fsm #(.DEV_ADDR(DEV_ADDR)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det),
        .busy      (busy),
        .sda_oe    (sda_oe),
        .cmd_fire  (cmd_fire),
        .cmd_byte  (cmd_byte)
    );

    cmd_launch u_launch (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_fire      (cmd_fire),
        .cmd_byte      (cmd_byte),
        .nv_we_n       (nv_we_n),
        .busy          (busy),
        .start_save    (start_save),
        .start_restore (start_restore)
    );

    // R4: any request follows a STOP strobe two clocks earlier
    p_req_after_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (start_save || start_restore) |-> $past(stop_det, 2));

    // R2: save and restore are never requested together
    p_req_exclusive_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_save && start_restore));

endmodule

// File: tb/sim_cfg_save_restore_target.sv
module sim_cfg_save_restore_target;

    localparam logic [6:0] ADDR = 7'h3C;
    localparam int H = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic nv_we_n = 1'b0;
    logic busy = 1'b0;
    logic sda_oe, start_save, start_restore;
    wire  sda_line = sda_m & ~sda_oe;

    int n_checks = 0;
    int n_fail = 0;
    int save_cnt = 0;
    int rest_cnt = 0;

    always #5 clk = ~clk;

    cfg_save_restore_target #(.DEV_ADDR(ADDR)) u0 (
        .clk(clk), .rst_n(rst_n), .scl_in(scl_m), .sda_in(sda_line),
        .sda_oe(sda_oe), .nv_we_n(nv_we_n), .busy(busy),
        .start_save(start_save), .start_restore(start_restore)
    );

    // count request pulses seen at the outputs
    always @(posedge clk) begin
        if (start_save)    save_cnt <= save_cnt + 1;
        if (start_restore) rest_cnt <= rest_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic i2c_start;
        sda_m = 1'b1; wt(H);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b0; wt(H);
        scl_m = 1'b0; wt(H);
    endtask

    task automatic i2c_stop;
        sda_m = 1'b0; wt(H);
        scl_m = 1'b1; wt(H);
        sda_m = 1'b1; wt(H);
    endtask

    task automatic i2c_byte(input logic [7:0] b, output bit acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(H);
            scl_m = 1'b1; wt(H);
            scl_m = 1'b0; wt(H);
        end
        sda_m = 1'b1; wt(H);
        scl_m = 1'b1; wt(H/2);
        acked = !sda_line;
        wt(H/2);
        scl_m = 1'b0; wt(H);
        // R10: driver released after the ninth clock falls
        chk(sda_oe == 1'b0, "R10 oe released", int'(sda_oe), 0);
    endtask

    // full command: returns both ack bits, pulse counts before STOP checked
    task automatic xfer(input logic [6:0] a, input bit rw, input logic [7:0] c,
                        output bit ack_a, output bit ack_c);
        int s0, r0;
        s0 = save_cnt; r0 = rest_cnt;
        i2c_start;
        i2c_byte({a, rw}, ack_a);
        i2c_byte(c, ack_c);
        chk(save_cnt == s0 && rest_cnt == r0, "R4 no request before STOP",
            save_cnt + rest_cnt - s0 - r0, 0);
        i2c_stop;
        wt(H);
    endtask

    task automatic t_reset;
        chk(sda_oe == 0, "R11 sda_oe reset", int'(sda_oe), 0);
        chk(start_save == 0 && start_restore == 0, "R11 pulses reset",
            int'(start_save) + int'(start_restore), 0);
    endtask

    task automatic t_save;
        bit aa, ac; int s0;
        s0 = save_cnt;
        xfer(ADDR, 1'b0, 8'h01, aa, ac);
        chk(aa, "R1 address ack", int'(aa), 1);
        chk(ac, "R2 command ack", int'(ac), 1);
        chk(save_cnt == s0 + 1, "R2 one save pulse", save_cnt - s0, 1);
        s0 = save_cnt;
        xfer(ADDR, 1'b0, 8'hFD, aa, ac);
        chk(save_cnt == s0 + 1, "R2 upper bits ignored", save_cnt - s0, 1);
    endtask

    task automatic t_restore;
        bit aa, ac; int r0, s0;
        r0 = rest_cnt; s0 = save_cnt;
        xfer(ADDR, 1'b0, 8'hA6, aa, ac);
        chk(rest_cnt == r0 + 1, "R3 one restore pulse", rest_cnt - r0, 1);
        chk(save_cnt == s0, "R3 no save pulse", save_cnt - s0, 0);
    endtask

    task automatic t_we_blocked;
        bit aa, ac; int s0;
        nv_we_n = 1'b1;
        s0 = save_cnt;
        xfer(ADDR, 1'b0, 8'h01, aa, ac);
        chk(save_cnt == s0, "R9 save blocked by write enable", save_cnt - s0, 0);
        nv_we_n = 1'b0;
    endtask

    task automatic t_nop_codes;
        bit aa, ac; int s0, r0;
        s0 = save_cnt; r0 = rest_cnt;
        xfer(ADDR, 1'b0, 8'h00, aa, ac);
        chk(ac, "R8 code 00 acked", int'(ac), 1);
        xfer(ADDR, 1'b0, 8'h5F, aa, ac);
        chk(ac, "R8 code 11 acked", int'(ac), 1);
        chk(save_cnt == s0 && rest_cnt == r0, "R8 no request",
            save_cnt + rest_cnt - s0 - r0, 0);
    endtask

    task automatic t_mismatch;
        bit aa, ac; int s0;
        s0 = save_cnt;
        xfer(ADDR ^ 7'h01, 1'b0, 8'h01, aa, ac);
        chk(!aa, "R6 address nack", int'(aa), 0);
        chk(!ac, "R6 command nack", int'(ac), 0);
        chk(save_cnt == s0, "R6 no request", save_cnt - s0, 0);
        xfer(ADDR, 1'b1, 8'h01, aa, ac);
        chk(!aa, "R1 read nack", int'(aa), 0);
    endtask

    task automatic t_rep_start;
        bit aa, ac; int s0;
        s0 = save_cnt;
        i2c_start;
        i2c_byte({ADDR, 1'b0}, aa);
        i2c_byte(8'h01, ac);
        i2c_start;
        i2c_byte({ADDR, 1'b0}, aa);
        chk(aa, "R7 new address phase acked", int'(aa), 1);
        i2c_start;
        i2c_stop;
        wt(H);
        chk(save_cnt == s0, "R7 pending command discarded", save_cnt - s0, 0);
    endtask

    task automatic t_busy;
        bit aa, ac; int r0;
        busy = 1'b1;
        r0 = rest_cnt;
        xfer(ADDR, 1'b0, 8'h02, aa, ac);
        chk(!aa, "R5 nack while busy", int'(aa), 0);
        chk(rest_cnt == r0, "R5 no request while busy", rest_cnt - r0, 0);
        busy = 1'b0;
        xfer(ADDR, 1'b0, 8'h02, aa, ac);
        chk(aa, "R5 ack resumes", int'(aa), 1);
        chk(rest_cnt == r0 + 1, "R5 restore after busy", rest_cnt - r0, 1);
    endtask

    task automatic finish_run;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run;
    end

    initial begin
        wt(4);
        rst_n = 1'b1;
        wt(2);
        t_reset;
        t_save;
        t_restore;
        t_we_blocked;
        t_nop_codes;
        t_mismatch;
        t_rep_start;
        t_busy;
        finish_run;
    end

endmodule